// File: doc/BRIEF.md
# Cascadable Dual Timer Pair

This block holds two 16-bit down-counters, called the low timer and the high timer. Each has its own reload value. A counter steps down by one on each tick. On a tick taken while it holds zero, it reloads and raises a one-cycle underflow pulse. A single clock-select register picks the tick source for each timer:

- a power-of-two division of the system clock, from 1 to 128;
- a rising edge on the timer's own external clock pin, brought into the clock domain by a synchronizer.

The high timer has two more choices. It can tick on every wrap of the low timer, which chains the pair into one 32-bit down-counter. It can also be halted.

Software reaches the block through a simple register port. A write to a count register overrides whatever tick happens in that cycle. Reads are combinational from a separate read address.

Top module: `cascade_timer_pair`

## Requirements
- R1: While `rst_n` is low, both counts, both reloads and the select register read zero, and both underflow outputs are low.
- R2: On each tick, a non-zero count decreases by one. A tick at count zero loads the reload value, and the matching underflow output is high for exactly the cycle after that edge.
- R3: Internal division uses a free-running 7-bit cycle counter that is zero out of reset and increases every cycle. With exponent field value e, a timer ticks on every edge where the low e bits of that counter are all ones, which is every 2^e cycles.
- R4: With pin clocking, a pin rising before clock edge k is counted at edge k+2. This covers a two-flop synchronizer followed by rising-edge detection, and only rising edges count.
- R5: With high source 2, the high timer ticks on the same edge at which the low timer wraps, so {high,low} behaves as one 32-bit down-counter.
- R6: With high source 3, the high count holds and the high underflow output stays low.
- R7: A write to a count register loads the written value at the next edge. A tick in the same cycle is ignored and produces no underflow.
- R8: A write to a reload register leaves the running count unchanged. A wrap on the same edge still uses the previous reload value.
- R9: The select register is at address 4 and keeps write bits [8:0]. Its fields are: low exponent [2:0], low pin select [3] (1 = pin), high exponent [6:4], and high source [8:7] (0 = divided clock, 1 = pin, 2 = low-timer wrap, 3 = halted). Bits [15:9] read zero.
- R10: The register addresses are: low count at 0, low reload at 1, high count at 2, high reload at 3. Addresses 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_lo_i | input | 1 | External clock pin for the low timer (asynchronous) |
| ext_clk_hi_i | input | 1 | External clock pin for the high timer (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| uf_lo_o | output | 1 | Low timer underflow pulse |
| uf_hi_o | output | 1 | High timer underflow pulse |

## Verification
The properties assume that every input is a known value once reset is released. They also assume a write strobe comes with a meaningful address, and that the pins may change at any time with respect to the clock. The stimulus drives every input, pins included, on the falling clock edge and never leaves one undefined. Random count values are kept small most of the time, so that wraps, cascaded ripples and reload collisions with writes occur often. Full 16-bit values are still mixed in.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

    localparam int EXP_W    = 3;
    localparam int RADDR_W  = 3;

    typedef enum logic [1:0] {
        HI_DIV     = 2'd0,
        HI_PIN     = 2'd1,
        HI_CASCADE = 2'd2,
        HI_HALT    = 2'd3
    } hi_src_e;

    // clock-select register image, bit 0 = LSB of lo_exp
    typedef struct packed {
        hi_src_e            hi_src;
        logic [EXP_W-1:0]   hi_exp;
        logic               lo_pin;
        logic [EXP_W-1:0]   lo_exp;
    } clk_sel_t;

    localparam int SEL_W = $bits(clk_sel_t);

    localparam logic [RADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [RADDR_W-1:0] A_RLD_LO = 3'd1;
    localparam logic [RADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [RADDR_W-1:0] A_RLD_HI = 3'd3;
    localparam logic [RADDR_W-1:0] A_SEL    = 3'd4;

endpackage

// File: rtl/ctp_prescaler.sv
module ctp_prescaler #(
    parameter int EXP_W = 3,
    parameter int NCH   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0][EXP_W-1:0] exp_i,
    output logic [NCH-1:0]            tick_o
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // a channel ticks when every bit below its exponent is set
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [PRE_W-1:0] keep;
        always_comb begin
            keep      = ~({PRE_W{1'b1}} << exp_i[g]);
            tick_o[g] = &(pre_q | ~keep);
        end
    end

endmodule

// File: rtl/ctp_pin_sync.sv
module ctp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], pin_i};
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/ctp_down_counter.sv
module ctp_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o,
    output logic         uf_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         uf;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wrap_o  = tick_i && !load_i && (st_q.cnt == '0);
        st_d.uf = wrap_o;
        if (load_i)
            st_d.cnt = load_val_i;
        else if (tick_i)
            st_d.cnt = (st_q.cnt == '0) ? reload_i : st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign uf_o    = st_q.uf;

endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
    import ctp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_clk_lo_i,
    input  logic               ext_clk_hi_i,
    input  logic               wr_en_i,
    input  logic [RADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    input  logic [RADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]   rd_data_o,
    output logic               uf_lo_o,
    output logic               uf_hi_o
);
    localparam int NT  = 2;
    localparam int PAD = CNT_W - SEL_W;

    typedef struct packed {
        logic [NT-1:0][CNT_W-1:0] rld;
        clk_sel_t                 sel;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NT-1:0]            pins, rise, div_tick, tick, load, wrap, uf;
    logic [NT-1:0][EXP_W-1:0] exps;
    logic [NT-1:0][CNT_W-1:0] cnt;

    // ---------------- register file ----------------
    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_RLD_LO: regs_d.rld[0] = wr_data_i;
                A_RLD_HI: regs_d.rld[1] = wr_data_i;
                A_SEL:    regs_d.sel    = clk_sel_t'(wr_data_i[SEL_W-1:0]);
                default:  ;
            endcase
        end
        load[0] = wr_en_i && (wr_addr_i == A_CNT_LO);
        load[1] = wr_en_i && (wr_addr_i == A_CNT_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // ---------------- tick sources ----------------
    assign pins    = {ext_clk_hi_i, ext_clk_lo_i};
    assign exps[0] = regs_q.sel.lo_exp;
    assign exps[1] = regs_q.sel.hi_exp;

    ctp_prescaler #(.EXP_W(EXP_W), .NCH(NT)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_i  (exps),
        .tick_o (div_tick)
    );

    for (genvar p = 0; p < NT; p++) begin : g_pin
        ctp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pins[p]),
            .rise_o (rise[p])
        );
    end

    always_comb begin
        tick[0] = regs_q.sel.lo_pin ? rise[0] : div_tick[0];
        case (regs_q.sel.hi_src)
            HI_DIV:     tick[1] = div_tick[1];
            HI_PIN:     tick[1] = rise[1];
            HI_CASCADE: tick[1] = wrap[0];
            default:    tick[1] = 1'b0;
        endcase
    end

    // ---------------- counters ----------------
    for (genvar t = 0; t < NT; t++) begin : g_tmr
        ctp_down_counter #(.W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick[t]),
            .load_i     (load[t]),
            .load_val_i (wr_data_i),
            .reload_i   (regs_q.rld[t]),
            .count_o    (cnt[t]),
            .wrap_o     (wrap[t]),
            .uf_o       (uf[t])
        );
    end

    assign uf_lo_o = uf[0];
    assign uf_hi_o = uf[1];

    // ---------------- read mux ----------------
    always_comb begin
        case (rd_addr_i)
            A_CNT_LO: rd_data_o = cnt[0];
            A_RLD_LO: rd_data_o = regs_q.rld[0];
            A_CNT_HI: rd_data_o = cnt[1];
            A_RLD_HI: rd_data_o = regs_q.rld[1];
            A_SEL:    rd_data_o = {{PAD{1'b0}}, regs_q.sel};
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/ctp_checker.sv
module ctp_checker
    import ctp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cnt_lo,
    input logic [CNT_W-1:0]   cnt_hi,
    input logic [CNT_W-1:0]   rld_lo,
    input logic               tick_lo,
    input logic               load_lo,
    input logic               load_hi,
    input logic [CNT_W-1:0]   load_val,
    input logic               uf_lo,
    input logic               uf_hi,
    input hi_src_e            hi_src,
    input logic [RADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]   rd_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!uf_lo && !uf_hi && cnt_lo == '0 && cnt_hi == '0));

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_lo && !load_lo && cnt_lo != '0) |=> (cnt_lo == $past(cnt_lo) - 1'b1));

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_lo |-> (cnt_lo == $past(rld_lo)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (cnt_lo == $past(load_val) && !uf_lo));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_src == HI_HALT && !load_hi) |=> ($stable(cnt_hi) && !uf_hi));

    // R5
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_src == HI_CASCADE && !load_hi && cnt_lo != '0) |=> $stable(cnt_hi));

    // R5
    cascade_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_hi && $past(hi_src) == HI_CASCADE) |-> uf_lo);

    // R10
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > A_SEL) |-> (rd_data == '0));

endmodule

bind cascade_timer_pair ctp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_lo   (cnt[0]),
    .cnt_hi   (cnt[1]),
    .rld_lo   (regs_q.rld[0]),
    .tick_lo  (tick[0]),
    .load_lo  (load[0]),
    .load_hi  (load[1]),
    .load_val (wr_data_i),
    .uf_lo    (uf_lo_o),
    .uf_hi    (uf_hi_o),
    .hi_src   (regs_q.sel.hi_src),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o)
);

// File: tb/cascade_timer_pair_bench.sv
`timescale 1ns/1ps
module cascade_timer_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_lo = 1'b0, pin_hi = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        uf_lo, uf_hi;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    string cur_req  = "R1";

    always #2 clk = ~clk;

    cascade_timer_pair u_cascade_timer_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_clk_lo_i (pin_lo),
        .ext_clk_hi_i (pin_hi),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .uf_lo_o      (uf_lo),
        .uf_hi_o      (uf_hi)
    );

    // ---------------- reference model (from the requirements) ----------------
    logic [15:0] m_cnt_lo, m_cnt_hi, m_rld_lo, m_rld_hi;
    logic [8:0]  m_sel;
    logic [6:0]  m_pre;
    logic [2:0]  m_sh_lo, m_sh_hi;
    logic        m_uf_lo, m_uf_hi;

    function automatic logic div_tick(logic [6:0] pre, logic [2:0] e);
        logic [6:0] mask;
        mask = (7'd1 << e) - 7'd1;
        return (pre & mask) == mask;
    endfunction

    function automatic logic [15:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0:    return m_cnt_lo;
            3'd1:    return m_rld_lo;
            3'd2:    return m_cnt_hi;
            3'd3:    return m_rld_hi;
            3'd4:    return {7'd0, m_sel};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : mdl
        logic e_lo, e_hi, t_lo, t_hi, ld_lo, ld_hi, w_lo, w_hi;
        logic [15:0] n_lo, n_hi;
        if (!rst_n) begin
            m_cnt_lo = '0; m_cnt_hi = '0; m_rld_lo = '0; m_rld_hi = '0;
            m_sel = '0; m_pre = '0; m_sh_lo = '0; m_sh_hi = '0;
            m_uf_lo = 1'b0; m_uf_hi = 1'b0;
        end else begin
            e_lo  = m_sh_lo[1] & ~m_sh_lo[2];
            e_hi  = m_sh_hi[1] & ~m_sh_hi[2];
            t_lo  = m_sel[3] ? e_lo : div_tick(m_pre, m_sel[2:0]);
            ld_lo = wr_en && wr_addr == 3'd0;
            ld_hi = wr_en && wr_addr == 3'd2;
            w_lo  = t_lo && !ld_lo && m_cnt_lo == 16'd0;
            case (m_sel[8:7])
                2'd0:    t_hi = div_tick(m_pre, m_sel[6:4]);
                2'd1:    t_hi = e_hi;
                2'd2:    t_hi = w_lo;
                default: t_hi = 1'b0;
            endcase
            w_hi = t_hi && !ld_hi && m_cnt_hi == 16'd0;
            n_lo = ld_lo ? wr_data : t_lo ? ((m_cnt_lo == 0) ? m_rld_lo : m_cnt_lo - 16'd1) : m_cnt_lo;
            n_hi = ld_hi ? wr_data : t_hi ? ((m_cnt_hi == 0) ? m_rld_hi : m_cnt_hi - 16'd1) : m_cnt_hi;
            if (wr_en) begin
                case (wr_addr)
                    3'd1:    m_rld_lo = wr_data;
                    3'd3:    m_rld_hi = wr_data;
                    3'd4:    m_sel    = wr_data[8:0];
                    default: ;
                endcase
            end
            m_cnt_lo = n_lo;
            m_cnt_hi = n_hi;
            m_uf_lo  = w_lo;
            m_uf_hi  = w_hi;
            m_pre    = m_pre + 7'd1;
            m_sh_lo  = {m_sh_lo[1:0], pin_lo};
            m_sh_hi  = {m_sh_hi[1:0], pin_hi};
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    // one cycle: check outputs at the falling edge, then drive the next inputs
    task automatic cycle(logic we, logic [2:0] wa, logic [15:0] wd);
        @(negedge clk);
        check("rd_data", rd_data, exp_rd(rd_addr));
        check("uf_lo", {15'd0, uf_lo}, {15'd0, m_uf_lo});
        check("uf_hi", {15'd0, uf_hi}, {15'd0, m_uf_hi});
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        rd_addr = 3'($urandom % 8);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        cycle(1'b1, a, d);
    endtask

    function automatic logic [15:0] small_val();
        return ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 24);
    endfunction

    // mode 0 none, 1 counts, 2 reloads, 3 select, 4 any address
    task automatic run(string tag, int n, int mode, int wpct, int ppct);
        cur_req = tag;
        for (int i = 0; i < n; i++) begin
            logic        we;
            logic [2:0]  wa;
            logic [15:0] wd;
            we = (mode != 0) && ($urandom % 100 < wpct);
            case (mode)
                1:       wa = 3'(($urandom % 2) * 2);
                2:       wa = 3'(($urandom % 2) * 2 + 1);
                3:       wa = 3'd4;
                default: wa = 3'($urandom % 8);
            endcase
            wd = (wa == 3'd4) ? 16'($urandom) : small_val();
            if ($urandom % 100 < ppct) pin_lo = ~pin_lo;
            if ($urandom % 100 < ppct) pin_hi = ~pin_hi;
            cycle(we, wa, wd);
        end
        wr_en = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd2718));
        // R1: state while reset is held
        cur_req = "R1";
        for (int a = 0; a < 5; a++) begin
            @(negedge clk);
            rd_addr = 3'(a);
            #1;
            check("reset rd_data", rd_data, 16'd0);
            check("reset uf", {14'd0, uf_hi, uf_lo}, 16'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: divide by one on both timers, short reloads
        cur_req = "R2";
        wr(3'd1, 16'd5);
        wr(3'd3, 16'd9);
        run("R2", 200, 0, 0, 0);

        // R3: several internal divide ratios
        for (int k = 0; k < 4; k++) begin
            cur_req = "R3";
            wr(3'd4, {7'd0, 2'd0, 3'($urandom % 8), 1'b0, 3'($urandom % 8)});
            wr(3'd1, 16'($urandom % 6));
            wr(3'd3, 16'($urandom % 6));
            run("R3", 600, 0, 0, 0);
        end

        // R4: both timers on their pins
        cur_req = "R4";
        wr(3'd4, 16'h0088);
        wr(3'd1, 16'd3);
        wr(3'd3, 16'd2);
        run("R4", 1500, 0, 0, 35);
        run("R4", 300, 0, 0, 3);

        // R5: 32-bit chaining, including a directed ripple through zero
        cur_req = "R5";
        wr(3'd4, 16'h0100);
        wr(3'd1, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'd2);
        wr(3'd2, 16'd1);
        run("R5", 40, 0, 0, 0);
        wr(3'd1, 16'd3);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'h0101);
        run("R5", 1000, 0, 0, 0);

        // R6: high timer halted
        cur_req = "R6";
        wr(3'd4, 16'h0180);
        run("R6", 300, 0, 0, 20);

        // R7: count writes colliding with ticks and wraps
        cur_req = "R7";
        wr(3'd4, 16'h0100);
        run("R7", 800, 1, 40, 0);
        wr(3'd4, 16'h0000);
        run("R7", 700, 1, 40, 0);

        // R8: reload writes against running counts
        cur_req = "R8";
        run("R8", 1000, 2, 30, 0);

        // R9: select register writes and readback
        run("R9", 1500, 3, 15, 25);

        // R10: every address including unused ones
        run("R10", 1500, 4, 30, 25);

        @(negedge clk);
        finish_run();
    end

endmodule